// File: doc/BRIEF.md
# Six-Product Correlating Multiply-Accumulator

This block correlates three signed sample streams. Each time a sample strobe is accepted, it captures one sample from each stream. Over the next six clock cycles it forms every square and every pairwise cross-product of the three samples, using a single multiplier. Each of the six results is added into its own 48-bit two's-complement accumulator.

A sequencer handles the rest:
- It routes the captured samples onto the two multiplicand buses.
- It chooses which accumulator takes the sum on each step.
- It counts accepted samples against a programmed integration length.

Accumulators are cleared when integration starts. Clearing uses the adder itself: the adder's feedback operand is forced to all ones and a carry of one is injected.

A host reads results one byte at a time. It picks an accumulator slot and a byte index, and gets the byte on an 8-bit registered output. Reads do not interfere with accumulation in progress.

Top module: `corr_mac6`

## Requirements
- R1: After reset, `integrating_o` is 0 and every accumulator and `rd_data_o` read as 0.
- R1 (continued): A `start_i` pulse raises `integrating_o` from the next cycle. The following six cycles clear slots 0 to 5, one per cycle. Each clear adds an all-ones feedback operand, a zero addend and a carry of one, which leaves zero.
- R2: Each accepted strobe adds exact signed products of the captured samples a, b and c, one to each slot:

  | Slot | Product |
  |---|---|
  | 0 | a·a |
  | 1 | b·b |
  | 2 | c·c |
  | 3 | a·b |
  | 4 | a·c |
  | 5 | b·c |

  Each sample is placed at the top of a 16-bit bus with two zero LSBs, and the four LSBs of the 32-bit product are dropped, so the product is exact.
- R3: Products are sign-extended to 48 bits before addition. Negative values and the extreme codes -8192 and 8191 accumulate exactly, modulo 2^48.
- R4: While reading, byte index k in 0..5 returns accumulator bits [8k+7:8k], with bit 47 as the MSB. Byte indices 6 and 7 return 0, and slot indices 6 and 7 return 0.
- R5: `rd_data_o` is registered. It shows the selected byte from the first rising edge at which `rd_en_i` is sampled high, and it is 0 after any edge at which `rd_en_i` is low.
- R6: `integrating_o` falls after the sixth step of the `nsamp_i`-th accepted sample. Strobes after that leave all accumulators unchanged.
- R7: A strobe that arrives during the clear pass, or while a six-step sequence is running, is ignored.
- R8: Reads issued during integration leave the accumulated results unchanged.
- R9: With `nsamp_i` = 0, integration ends right after the clear pass, and no strobe is accumulated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin integration: clear, then count samples |
| nsamp_i | input | 16 | Samples per integration, captured at start |
| strobe_i | input | 1 | Sample strobe; launches one six-step sequence |
| smp_a_i | input | 14 | Signed sample, stream a |
| smp_b_i | input | 14 | Signed sample, stream b |
| smp_c_i | input | 14 | Signed sample, stream c |
| rd_en_i | input | 1 | Read enable |
| rd_slot_i | input | 3 | Accumulator slot to read |
| rd_byte_i | input | 3 | Byte index within the slot |
| rd_data_o | output | 8 | Registered read byte |
| integrating_o | output | 1 | High from start until the sample count is reached |

## Verification
The hardest situation to provoke is a strobe that lands while the sequencer is busy, either during the clear pass or in the middle of a product sequence. Only the absence of any effect on the final sums reveals that such a strobe was ignored.

The bench holds strobe high for a second cycle carrying different sample values, and injects an extra strobe two cycles after start. It also raises read enable during a running sequence. All three integrations use small sample counts, so a miscounted sample would show up both in the sums and in the time at which `integrating_o` falls.

// File: rtl/corr_pkg.sv
package corr_pkg;

  localparam int NSRC   = 3;
  localparam int NPROD  = 6;
  localparam int STEP_W = 3;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_CLEAR = 2'd1,
    SQ_WAIT  = 2'd2,
    SQ_RUN   = 2'd3
  } seq_state_e;

  // Source routed onto the X bus for a given step.
  function automatic logic [1:0] x_src(input logic [STEP_W-1:0] step);
    case (step)
      3'd1:    x_src = 2'd1;
      3'd2:    x_src = 2'd2;
      3'd5:    x_src = 2'd1;
      default: x_src = 2'd0;
    endcase
  endfunction

  // Source routed onto the Y bus for a given step.
  function automatic logic [1:0] y_src(input logic [STEP_W-1:0] step);
    case (step)
      3'd1, 3'd3: y_src = 2'd1;
      3'd2, 3'd4,
      3'd5:       y_src = 2'd2;
      default:    y_src = 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/corr_seq.sv
module corr_seq
  import corr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  nsamp_i,
  input  logic              strobe_i,
  output logic              lat_en_o,
  output logic              wr_en_o,
  output logic              clr_o,
  output logic [STEP_W-1:0] slot_o,
  output logic              integrating_o
);

  localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(NPROD - 1);
  localparam logic [CNT_W-1:0]  CNT_ONE   = CNT_W'(1);

  seq_state_e        state_q, state_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [CNT_W-1:0]  nsamp_q, nsamp_d;

  always_comb begin
    state_d  = state_q;
    step_d   = step_q;
    cnt_d    = cnt_q;
    nsamp_d  = nsamp_q;
    lat_en_o = 1'b0;
    if (start_i) begin
      state_d = SQ_CLEAR;
      step_d  = '0;
      cnt_d   = '0;
      nsamp_d = nsamp_i;
    end else begin
      case (state_q)
        SQ_CLEAR: begin
          if (step_q == STEP_LAST) begin
            step_d  = '0;
            state_d = (nsamp_q == '0) ? SQ_IDLE : SQ_WAIT;
          end else begin
            step_d = step_q + 1'b1;
          end
        end
        SQ_WAIT: begin
          if (strobe_i) begin
            lat_en_o = 1'b1;
            state_d  = SQ_RUN;
            step_d   = '0;
          end
        end
        SQ_RUN: begin
          if (step_q == STEP_LAST) begin
            step_d  = '0;
            cnt_d   = cnt_q + CNT_ONE;
            state_d = ((cnt_q + CNT_ONE) == nsamp_q) ? SQ_IDLE : SQ_WAIT;
          end else begin
            step_d = step_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SQ_IDLE;
      step_q  <= '0;
      cnt_q   <= '0;
      nsamp_q <= '0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      cnt_q   <= cnt_d;
      nsamp_q <= nsamp_d;
    end
  end

  assign wr_en_o       = (state_q == SQ_CLEAR) || (state_q == SQ_RUN);
  assign clr_o         = (state_q == SQ_CLEAR);
  assign slot_o        = step_q;
  assign integrating_o = (state_q != SQ_IDLE);

  a_r1_rise_needs_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(integrating_o) |-> $past(start_i));

  a_r2_step_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_q <= STEP_LAST);

  a_r7_latch_starts_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lat_en_o && !start_i) |=> (state_q == SQ_RUN && step_q == '0));

  a_r6_ends_on_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SQ_RUN && step_q == STEP_LAST && (cnt_q + CNT_ONE) == nsamp_q && !start_i)
      |=> !integrating_o);

endmodule

// File: rtl/corr_steer_mul.sv
module corr_steer_mul
  import corr_pkg::*;
#(
  parameter int SAMPLE_W = 14,
  parameter int BUS_W    = 16,
  parameter int ACC_W    = 48
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           lat_en_i,
  input  logic [NSRC-1:0][SAMPLE_W-1:0]  smp_i,
  input  logic [STEP_W-1:0]              step_i,
  output logic [ACC_W-1:0]               addend_o
);

  localparam int PAD     = BUS_W - SAMPLE_W;
  localparam int PROD_W  = 2 * BUS_W;
  localparam int DROP    = 2 * PAD;
  localparam int TRUNC_W = PROD_W - DROP;

  logic [NSRC-1:0][SAMPLE_W-1:0] smp_q;
  logic [BUS_W-1:0]   x_bus, y_bus;
  logic [1:0]         xs, ys;
  logic signed [PROD_W-1:0] prod;
  logic [TRUNC_W-1:0] prod_tr;

  for (genvar s = 0; s < NSRC; s++) begin : g_cap
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       smp_q[s] <= '0;
      else if (lat_en_i) smp_q[s] <= smp_i[s];
    end
  end

  // Steering: each source lands left-justified on a bus or stays off it.
  always_comb begin
    xs    = x_src(step_i);
    ys    = y_src(step_i);
    x_bus = '0;
    y_bus = '0;
    for (int s = 0; s < NSRC; s++) begin
      if (xs == 2'(s)) x_bus = x_bus | {smp_q[s], {PAD{1'b0}}};
      if (ys == 2'(s)) y_bus = y_bus | {smp_q[s], {PAD{1'b0}}};
    end
  end

  assign prod     = $signed(x_bus) * $signed(y_bus);
  assign prod_tr  = prod[PROD_W-1:DROP];
  assign addend_o = {{(ACC_W-TRUNC_W){prod_tr[TRUNC_W-1]}}, prod_tr};

  a_r2_dropped_bits_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prod[DROP-1:0] == '0);

endmodule

// File: rtl/corr_acc_bank.sv
module corr_acc_bank
  import corr_pkg::*;
#(
  parameter int ACC_W = 48
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              clr_i,
  input  logic [STEP_W-1:0] slot_i,
  input  logic [ACC_W-1:0]  addend_i,
  input  logic              rd_en_i,
  input  logic [2:0]        rd_slot_i,
  input  logic [2:0]        rd_byte_i,
  output logic [7:0]        rd_data_o
);

  localparam int NBYTE = ACC_W / 8;

  logic [ACC_W-1:0] acc_q [NPROD];
  logic [ACC_W-1:0] word_sel;
  logic [7:0]       rd_d, rd_q;

  for (genvar i = 0; i < NPROD; i++) begin : g_slot
    logic [ACC_W-1:0] fb, add, acc_d;
    logic             upd;

    always_comb begin
      fb    = clr_i ? '1 : acc_q[i];
      add   = clr_i ? '0 : addend_i;
      acc_d = fb + add + {{(ACC_W-1){1'b0}}, clr_i};
      upd   = wr_en_i && (slot_i == STEP_W'(i));
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  acc_q[i] <= '0;
      else if (upd) acc_q[i] <= acc_d;
    end

    a_r1_clear_leaves_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && clr_i && slot_i == STEP_W'(i)) |=> (acc_q[i] == '0));

    a_r8_hold_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(wr_en_i && slot_i == STEP_W'(i)) |=> $stable(acc_q[i]));
  end

  always_comb begin
    word_sel = '0;
    for (int i = 0; i < NPROD; i++)
      if (rd_slot_i == 3'(i)) word_sel = acc_q[i];
    rd_d = '0;
    if (rd_en_i)
      for (int b = 0; b < NBYTE; b++)
        if (rd_byte_i == 3'(b)) rd_d = word_sel[b*8 +: 8];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_q <= '0;
    else         rd_q <= rd_d;
  end

  assign rd_data_o = rd_q;

  a_r5_idle_output_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> (rd_data_o == '0));

  a_r4_pad_byte_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && rd_byte_i >= 3'(NBYTE)) |=> (rd_data_o == '0));

endmodule

// File: rtl/corr_mac6.sv
module corr_mac6
  import corr_pkg::*;
#(
  parameter int SAMPLE_W = 14,
  parameter int BUS_W    = 16,
  parameter int ACC_W    = 48,
  parameter int CNT_W    = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [CNT_W-1:0]    nsamp_i,
  input  logic                strobe_i,
  input  logic [SAMPLE_W-1:0] smp_a_i,
  input  logic [SAMPLE_W-1:0] smp_b_i,
  input  logic [SAMPLE_W-1:0] smp_c_i,
  input  logic                rd_en_i,
  input  logic [2:0]          rd_slot_i,
  input  logic [2:0]          rd_byte_i,
  output logic [7:0]          rd_data_o,
  output logic                integrating_o
);

  logic [1:0]               rst_sync_q;
  logic                     rst_n;
  logic                     lat_en, wr_en, clr;
  logic [STEP_W-1:0]        slot;
  logic [ACC_W-1:0]         addend;
  logic [NSRC-1:0][SAMPLE_W-1:0] smp;

  // Asynchronous assert, synchronous release.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  assign smp = {smp_c_i, smp_b_i, smp_a_i};

  corr_seq #(.CNT_W(CNT_W)) u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_n),
    .start_i       (start_i),
    .nsamp_i       (nsamp_i),
    .strobe_i      (strobe_i),
    .lat_en_o      (lat_en),
    .wr_en_o       (wr_en),
    .clr_o         (clr),
    .slot_o        (slot),
    .integrating_o (integrating_o)
  );

  corr_steer_mul #(.SAMPLE_W(SAMPLE_W), .BUS_W(BUS_W), .ACC_W(ACC_W)) u_mul (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .lat_en_i (lat_en),
    .smp_i    (smp),
    .step_i   (slot),
    .addend_o (addend)
  );

  corr_acc_bank #(.ACC_W(ACC_W)) u_acc (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .wr_en_i   (wr_en),
    .clr_i     (clr),
    .slot_i    (slot),
    .addend_i  (addend),
    .rd_en_i   (rd_en_i),
    .rd_slot_i (rd_slot_i),
    .rd_byte_i (rd_byte_i),
    .rd_data_o (rd_data_o)
  );

endmodule

// File: tb/corr_mac6_test.sv
module corr_mac6_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [15:0] nsamp;
  logic        strobe;
  logic [13:0] sa, sb, sc;
  logic        rd_en;
  logic [2:0]  rd_slot, rd_byte;
  logic [7:0]  rd_data;
  logic        integ;

  int tests = 0;
  int fails = 0;

  localparam int NV = 8;
  localparam int VA [NV] = '{8191, -8192, 8191,  -1,  123,  0, -3000, 4096};
  localparam int VB [NV] = '{8191, -8192, -8192, -1, -456,  5,  2000,   -1};
  localparam int VC [NV] = '{8191, -8192, 1,     -1,  789, -7, -1000, 8191};

  longint exp_sum [6];

  always #2 clk = ~clk;

  corr_mac6 uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .nsamp_i(nsamp),
    .strobe_i(strobe), .smp_a_i(sa), .smp_b_i(sb), .smp_c_i(sc),
    .rd_en_i(rd_en), .rd_slot_i(rd_slot), .rd_byte_i(rd_byte),
    .rd_data_o(rd_data), .integrating_o(integ)
  );

  task automatic chk(string req, logic [47:0] got, logic [47:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic rd(input int slot, input int b, output logic [7:0] v);
    @(negedge clk);
    rd_en = 1'b1; rd_slot = 3'(slot); rd_byte = 3'(b);
    @(negedge clk);
    v = rd_data;
    rd_en = 1'b0;
  endtask

  task automatic rd_word(input int slot, output logic [47:0] w);
    logic [7:0] v;
    for (int b = 0; b < 6; b++) begin
      rd(slot, b, v);
      w[b*8 +: 8] = v;
    end
  endtask

  task automatic set_smp(input int a, input int b, input int c);
    sa = a[13:0]; sb = b[13:0]; sc = c[13:0];
  endtask

  task automatic add_exp(input int a, input int b, input int c);
    exp_sum[0] += longint'(a) * a;
    exp_sum[1] += longint'(b) * b;
    exp_sum[2] += longint'(c) * c;
    exp_sum[3] += longint'(a) * b;
    exp_sum[4] += longint'(a) * c;
    exp_sum[5] += longint'(b) * c;
  endtask

  task automatic pulse_sample(input int a, input int b, input int c);
    @(negedge clk);
    set_smp(a, b, c); strobe = 1'b1;
    @(negedge clk);
    strobe = 1'b0;
    repeat (7) @(negedge clk);
  endtask

  task automatic begin_int(input int n);
    @(negedge clk);
    start = 1'b1; nsamp = 16'(n);
    @(negedge clk);
    start = 1'b0;
    chk("R1 integrating rises after start", 48'(integ), 48'd1);
    for (int i = 0; i < 6; i++) exp_sum[i] = 0;
  endtask

  task automatic check_all(string req);
    logic [47:0] w;
    for (int s = 0; s < 6; s++) begin
      rd_word(s, w);
      chk(req, w, exp_sum[s][47:0]);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0]  v;
    logic [47:0] w;
    rst_n = 1'b0; start = 1'b0; nsamp = '0; strobe = 1'b0;
    sa = '0; sb = '0; sc = '0; rd_en = 1'b0; rd_slot = '0; rd_byte = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk("R1 integrating after reset", 48'(integ), 48'd0);
    chk("R1 rd_data after reset", 48'(rd_data), 48'd0);
    for (int i = 0; i < 6; i++) exp_sum[i] = 0;
    check_all("R1 accumulator zero after reset");

    // Table-driven integration of NV samples; stray strobe during clear (R7)
    @(negedge clk);
    start = 1'b1; nsamp = 16'(NV);
    @(negedge clk);
    start = 1'b0;
    chk("R1 integrating rises after start", 48'(integ), 48'd1);
    for (int i = 0; i < 6; i++) exp_sum[i] = 0;
    @(negedge clk);
    set_smp(100, 100, 100); strobe = 1'b1;
    @(negedge clk);
    strobe = 1'b0;
    repeat (6) @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      pulse_sample(VA[i], VB[i], VC[i]);
      add_exp(VA[i], VB[i], VC[i]);
      chk("R6 integrating while counting", 48'(integ), (i < NV - 1) ? 48'd1 : 48'd0);
    end
    check_all("R2 R3 R7 accumulated sums, signed extremes");

    // R4: byte map pad and slot pad; R5: disabled output
    rd(0, 6, v); chk("R4 byte index 6 is zero", 48'(v), 48'd0);
    rd(0, 7, v); chk("R4 byte index 7 is zero", 48'(v), 48'd0);
    rd(6, 0, v); chk("R4 slot index 6 is zero", 48'(v), 48'd0);
    rd(0, 5, v); chk("R4 byte 5 holds bits 47:40", 48'(v), 48'(exp_sum[0][47:40]));
    @(negedge clk);
    chk("R5 output zero with read disabled", 48'(rd_data), 48'd0);
    // R5: registered latency - not visible before the edge
    @(posedge clk);
    #1 rd_en = 1'b1; rd_slot = 3'd3; rd_byte = 3'd0;
    #0.5;
    chk("R5 output not yet updated before edge", 48'(rd_data), 48'd0);
    @(negedge clk);
    chk("R5 byte after next rising edge", 48'(rd_data), 48'(exp_sum[3][7:0]));
    rd_en = 1'b0;

    // R6: strobe after integration end is ignored
    pulse_sample(777, 777, 777);
    check_all("R6 sums unchanged after end");

    // Second run: overlapping strobe (R7) and reads during run (R8)
    begin_int(3);
    repeat (6) @(negedge clk);
    @(negedge clk);
    set_smp(10, 20, 30); strobe = 1'b1;
    @(negedge clk);
    set_smp(1000, 1000, 1000);
    @(negedge clk);
    strobe = 1'b0;
    repeat (6) @(negedge clk);
    add_exp(10, 20, 30);
    @(negedge clk);
    set_smp(-50, 60, -70); strobe = 1'b1;
    rd_en = 1'b1; rd_slot = 3'd5; rd_byte = 3'd0;
    @(negedge clk);
    strobe = 1'b0; rd_slot = 3'd2; rd_byte = 3'd1;
    repeat (3) @(negedge clk);
    rd_en = 1'b0;
    repeat (4) @(negedge clk);
    add_exp(-50, 60, -70);
    chk("R7 integrating still high before third sample", 48'(integ), 48'd1);
    pulse_sample(-8192, 8191, -8192);
    add_exp(-8192, 8191, -8192);
    chk("R6 integrating low after third sample", 48'(integ), 48'd0);
    check_all("R8 R7 sums with reads and overlap");

    // R9: zero sample count
    begin_int(0);
    repeat (6) @(negedge clk);
    chk("R9 integration ends after clear", 48'(integ), 48'd0);
    pulse_sample(5, 5, 5);
    check_all("R9 no accumulation, cleared");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule